// File: doc/BRIEF.md
# Gated Frequency Threshold Monitor

This block watches a pulse train that has no fixed phase relation to the local clock, such as the output of a rotary encoder, and reports whether its rate has crossed one or two fixed limits. The pulse input is brought into the clock domain through a short flip-flop chain. Each rising edge is then counted over a gate of a fixed number of clock cycles. With a 50 MHz clock the default gate is 50,000,000 cycles, so the default limits of 1000 and 2000 edges per gate are limits in hertz.

When a gate ends, the edge total is compared with both limits and two registered alarm flags are loaded. The flags then keep their value until the next gate ends. The upper alarm always raises the lower one as well. The counter restarts on the same cycle the gate closes, with no dead cycle. An edge seen on that closing cycle is counted in the new gate. The gate length and both limits are parameters, so the block can be scaled to other clocks or rates.

Top module: `freq_alarm_monitor`

## Requirements
- R1: While `rst` is high, and for the first GATE_CYCLES clock edges after `rst` falls, `alarmLow` and `alarmHigh` are both 0.
- R2: The flags change only on the clock edge that closes a gate. Gates are exactly GATE_CYCLES cycles long, and the first one starts at the first clock edge with `rst` low.
- R3: If a gate counted HIGH_THRESH or more rising edges, the flags after that gate are `alarmLow`=1 and `alarmHigh`=1.
- R4: If a gate counted at least LOW_THRESH but fewer than HIGH_THRESH edges, the flags are `alarmLow`=1 and `alarmHigh`=0.
- R5: If a gate counted fewer than LOW_THRESH edges, both flags are 0.
- R6: `alarmHigh`=1 never appears while `alarmLow`=0.
- R7: A rising edge detected on the closing cycle of a gate counts in the following gate. No edge is lost or counted twice across the boundary.
- R8: The edge total saturates at its largest value and does not wrap. An input toggling on every clock therefore reads as at or above both limits.
- R9: Only rising edges count. `sigIn` passes through two flip-flops and one more sample stage, and a level held high for a whole gate counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sigIn | input | 1 | Asynchronous pulse input being measured |
| alarmLow | output | 1 | Set when the last gate reached LOW_THRESH edges |
| alarmHigh | output | 1 | Set when the last gate reached HIGH_THRESH edges |

## Verification
The hardest case to reach is a rising edge that the detector reports on exactly the closing cycle of a gate. The input has to rise three clock edges before the gate ends, allowing for the synchronizer delay. The bench counts cycles from a known gate start and places the rise there, with one edge short of the upper limit already sent in the old gate. The old gate must then report the middle level, and the carried edge must lift a following gate of LOW_THRESH-1 pulses to that same level. Saturation is reached with a gate long enough that a wrapping counter would fall back below the lower limit.

// File: rtl/freqmon_pkg.sv
package freqmon_pkg;

  // Strobes sent by the gate control to the counting datapath.
  typedef struct packed {
    logic evaluate;   // closing cycle of the gate: load flags from the total
    logic restart;    // start a fresh total on the same cycle
    logic countEdge;  // a synchronized rising edge was detected this cycle
  } gateStrobes_t;

  typedef enum logic [1:0] {
    LEVEL_NONE = 2'b00,
    LEVEL_LOW  = 2'b01,
    LEVEL_HIGH = 2'b11
  } alarmLevel_t;

endpackage

// File: rtl/freqmon_sync.sv
module freqmon_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic edgePulse
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevSample;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevSample <= 1'b0;
    else     prevSample <= syncChain[SYNC_STAGES-1];
  end

  assign edgePulse = syncChain[SYNC_STAGES-1] & ~prevSample;

  // A detected edge lasts one cycle only (R9).
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    edgePulse |=> !edgePulse);

endmodule

// File: rtl/freqmon_ctrl.sv
module freqmon_ctrl
  import freqmon_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000,
  parameter int TMR_W       = $clog2(GATE_CYCLES)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         edgePulse,
  output gateStrobes_t strobes
);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(GATE_CYCLES - 1);

  logic [TMR_W-1:0] gateTimer;
  logic             gateEnd;

  assign gateEnd = (gateTimer == '0);

  always_ff @(posedge clk) begin
    if (rst)          gateTimer <= RELOAD;
    else if (gateEnd) gateTimer <= RELOAD;
    else              gateTimer <= gateTimer - 1'b1;
  end

  always_comb begin
    strobes.evaluate  = gateEnd;
    strobes.restart   = gateEnd;
    strobes.countEdge = edgePulse;
  end

  // The timer stays inside one gate and moves every cycle (R2).
  assert_timer_range_R2: assert property (@(posedge clk) disable iff (rst)
    gateTimer <= RELOAD);
  assert_timer_moves_R2: assert property (@(posedge clk) disable iff (rst)
    !gateEnd |=> (gateTimer == $past(gateTimer) - 1'b1));

endmodule

// File: rtl/freqmon_dp.sv
module freqmon_dp
  import freqmon_pkg::*;
#(
  parameter int LOW_THRESH  = 1000,
  parameter int HIGH_THRESH = 2000,
  parameter int CNT_W       = $clog2(HIGH_THRESH + 1) + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  gateStrobes_t strobes,
  output alarmLevel_t  level
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_THRESH);
  localparam logic [CNT_W-1:0] HIGH_C  = CNT_W'(HIGH_THRESH);

  logic [CNT_W-1:0] edgeCount;
  alarmLevel_t      nextLevel;

  always_ff @(posedge clk) begin
    if (rst)
      edgeCount <= '0;
    else if (strobes.restart)
      edgeCount <= {{(CNT_W-1){1'b0}}, strobes.countEdge};
    else if (strobes.countEdge && edgeCount != CNT_MAX)
      edgeCount <= edgeCount + 1'b1;
  end

  always_comb begin
    if (edgeCount >= HIGH_C)     nextLevel = LEVEL_HIGH;
    else if (edgeCount >= LOW_C) nextLevel = LEVEL_LOW;
    else                         nextLevel = LEVEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                   level <= LEVEL_NONE;
    else if (strobes.evaluate) level <= nextLevel;
  end

  assert_level_order_R6: assert property (@(posedge clk) disable iff (rst)
    level[1] |-> level[0]);
  assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.evaluate |=> $stable(level));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (edgeCount == CNT_MAX && !strobes.restart) |=> edgeCount == CNT_MAX);
  assert_carry_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.restart && strobes.countEdge) |=> edgeCount == 1);

endmodule

// File: rtl/freq_alarm_monitor.sv
module freq_alarm_monitor
  import freqmon_pkg::*;
#(
  parameter int GATE_CYCLES = 50_000_000,
  parameter int LOW_THRESH  = 1000,
  parameter int HIGH_THRESH = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic sigIn,
  output logic alarmLow,
  output logic alarmHigh
);
  localparam int TMR_W = $clog2(GATE_CYCLES);
  localparam int CNT_W = $clog2(HIGH_THRESH + 1) + 1;

  logic         edgePulse;
  gateStrobes_t strobes;
  alarmLevel_t  level;

  freqmon_sync #(.SYNC_STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .asyncIn(sigIn), .edgePulse(edgePulse)
  );

  freqmon_ctrl #(.GATE_CYCLES(GATE_CYCLES), .TMR_W(TMR_W)) i_ctrl (
    .clk(clk), .rst(rst), .edgePulse(edgePulse), .strobes(strobes)
  );

  freqmon_dp #(.LOW_THRESH(LOW_THRESH), .HIGH_THRESH(HIGH_THRESH), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .level(level)
  );

  assign alarmLow  = level[0];
  assign alarmHigh = level[1];

  // Nothing is raised before the first gate has closed (R1).
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!alarmLow && !alarmHigh));

endmodule

// File: tb/test_freq_alarm_monitor.sv
module test_freq_alarm_monitor;
  localparam int GATE = 260;
  localparam int LOW  = 10;
  localparam int HIGH = 20;
  localparam int SATMAX = 63;  // six-bit total for HIGH=20

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sigIn = 1'b0;
  logic alarmLow, alarmHigh;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference
  int hist[$] = '{0, 0, 0};
  int mTimer = GATE - 1;
  int mCount = 0;
  int mLow = 0;
  int mHigh = 0;

  freq_alarm_monitor #(.GATE_CYCLES(GATE), .LOW_THRESH(LOW), .HIGH_THRESH(HIGH)) i_freq_alarm_monitor (
    .clk(clk), .rst(rst), .sigIn(sigIn), .alarmLow(alarmLow), .alarmHigh(alarmHigh)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int seen;
    if (rst) begin
      hist = '{0, 0, 0};
      mTimer = GATE - 1; mCount = 0; mLow = 0; mHigh = 0;
    end else begin
      seen = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      if (mTimer == 0) begin
        mLow  = (mCount >= LOW)  ? 1 : 0;
        mHigh = (mCount >= HIGH) ? 1 : 0;
        mCount = seen;
        mTimer = GATE - 1;
      end else begin
        mCount = (mCount + seen > SATMAX) ? SATMAX : mCount + seen;
        mTimer = mTimer - 1;
      end
      hist.push_front(int'(sigIn));
      void'(hist.pop_back());
    end
  end

  task automatic check(input logic expLow, input logic expHigh, input string tag);
    checks++;
    if (alarmLow !== expLow || alarmHigh !== expHigh) begin
      fails++;
      $display("FAIL %s: flags got %b%b expected %b%b at cycle %0d",
               tag, alarmHigh, alarmLow, expHigh, expLow, cycles);
    end
  endtask

  // compare with the reference on every clock
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(mLow[0], mHigh[0], "R2 model");
      checks++;
      if (alarmHigh && !alarmLow) begin
        fails++;
        $display("FAIL R6: flags got %b%b expected not 10", alarmHigh, alarmLow);
      end
    end
  end

  task automatic finishRun;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  // one gate with n pulses of four cycles, then check the flags it produced
  task automatic runWindow(input int n, input logic eLow, input logic eHigh, input string tag);
    for (int k = 0; k < n; k++) begin
      sigIn = 1'b1; repeat (2) @(negedge clk);
      sigIn = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (GATE - 4 * n) @(negedge clk);
    check(eLow, eHigh, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, "R1 in reset");
    rst = 1'b0;

    // first gate: toggle every cycle, far beyond the counter range
    for (int i = 0; i < GATE - 1; i++) begin
      sigIn = ~sigIn; @(negedge clk);
    end
    check(1'b0, 1'b0, "R1 before first gate end");
    sigIn = ~sigIn; @(negedge clk);
    check(1'b1, 1'b1, "R8 saturated total");
    sigIn = 1'b0;

    runWindow(0,  1'b0, 1'b0, "R5 quiet");
    runWindow(9,  1'b0, 1'b0, "R5 one below low");
    runWindow(10, 1'b1, 1'b0, "R4 at low");
    runWindow(19, 1'b1, 1'b0, "R4 one below high");
    runWindow(20, 1'b1, 1'b1, "R3 at high");
    runWindow(21, 1'b1, 1'b1, "R3 above high");
    runWindow(0,  1'b0, 1'b0, "R5 back to quiet");

    // level held high: one edge only
    sigIn = 1'b1; repeat (GATE - 5) @(negedge clk);
    sigIn = 1'b0; repeat (5) @(negedge clk);
    check(1'b0, 1'b0, "R9 held level");

    // edge placed on the closing cycle of the gate
    for (int k = 0; k < HIGH - 1; k++) begin
      sigIn = 1'b1; repeat (2) @(negedge clk);
      sigIn = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (GATE - 3 - 4 * (HIGH - 1)) @(negedge clk);
    sigIn = 1'b1; repeat (3) @(negedge clk);
    check(1'b1, 1'b0, "R7 boundary edge not in old gate");
    sigIn = 1'b0; repeat (2) @(negedge clk);
    for (int k = 0; k < LOW - 1; k++) begin
      sigIn = 1'b1; repeat (2) @(negedge clk);
      sigIn = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (GATE - 2 - 4 * (LOW - 1)) @(negedge clk);
    check(1'b1, 1'b0, "R7 boundary edge in new gate");

    repeat (GATE / 2) @(negedge clk);
    check(1'b1, 1'b0, "R2 held mid gate");
    repeat (GATE - GATE / 2) @(negedge clk);
    check(1'b0, 1'b0, "R5 after idle gate");

    finishRun();
  end
endmodule